// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block runs one serial management transaction to an external PHY for every host write. The host writes a 32-bit frame word. The word is loaded into a circulating shift register, and the block starts clocking it out on the management data line straight away. The management clock is divided down from the system clock. On each management clock cycle, the top bit of the register goes out on the data line, and one bit comes back into the bottom of the register.

Header bits that the block drives itself loop back into the register unchanged. Bits that the PHY drives replace the data field. When all 32 cycles have finished, the word is back in its original bit order. For a read frame, its low 16 bits then hold what the PHY returned. At any moment the host can read the register and see its live, partly rotated contents. An idle flag and a one-cycle interrupt mark the end of each frame.

The header layout selects the frame type. The block drives clause 22 read frames and clause 45 read frames only through the header. For these frames it releases the data line during the last 16 cycles, so the PHY can answer.

Top module: `mdio_mgmt_shift`

## Requirements
- R1: During and after reset, `mgmt_idle` is 1, `mgmt_irq` is 0, `mdc` is 0, `mdio_oe` is 0 and `host_rdata` is 0.
- R2: A `host_wr` sampled while idle loads `host_wdata` and starts a frame at that same clock edge. After that edge, `mgmt_idle` is 0 and `mdio_out` shows bit 31 of the written word.
- R3: While a frame runs, `mdc` has a period of MDC_DIV clocks. Its first MDC_DIV/2 clocks after the start are low and the remaining clocks are high. When idle, `mdc` is held low.
- R4: Each MDC cycle presents the current register MSB on `mdio_out`. That output changes only on a falling edge of `mdc`. The input bit is sampled at the clock edge where `mdc` rises.
- R5: A frame lasts exactly 32 MDC cycles. `mgmt_idle` rises 32*MDC_DIV clocks after the edge that accepted the write.
- R6: `mgmt_irq` is high for exactly one clock, in the clock where `mgmt_idle` has just risen.
- R7: After k complete MDC cycles of a frame whose bits are all driven by the block, `host_rdata` equals the written word rotated left by k.
- R8: A frame that is not a read pattern (see R9 and R10) drives all 32 bits, with `mdio_oe` high. The bits go out MSB first, and the register ends equal to the written word.
- R9: A clause 22 read has bits[31:30]=01 and bits[29:28]=10. For this frame, `mdio_oe` is high for the first 16 bits and low for the last 16 bits. The register ends with bits[31:16] as written and bits[15:0] holding the 16 input bits, the first one received in bit 15.
- R10: A clause 45 frame has bits[31:30]=00. Opcodes bits[29:28]=11 and 10 are reads and behave as in R9. Opcodes 00 and 01 behave as in R8.
- R11: A `host_wr` while a frame is in progress is ignored. The running frame, its final contents and its completion time are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe for the frame register |
| host_wdata | input | 32 | Frame word to load |
| host_rdata | output | 32 | Live frame register contents |
| mgmt_idle | output | 1 | High when no frame is running |
| mgmt_irq | output | 1 | One-clock pulse when a frame completes |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input value |

## Verification
The bench builds the block with MDC_DIV=4, so a whole frame takes 128 clocks. This makes it cheap to run every frame type back to back. The short frames also let the bench check the exact completion clock, the shape of each MDC phase, and a mid-frame read at a known rotation. A PHY model in the bench counts rising edges of `mdc` on its own. From that count it answers read frames with the data bits and records the serial stream and output enable at every bit position.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_W = 32;
    localparam int DATA_W  = 16;
    localparam int HDR_W   = FRAME_W - DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [CNT_W-1:0]   bitcnt_t;

    typedef enum logic [1:0] {
        START_EXT  = 2'b00,
        START_BASE = 2'b01,
        START_R2   = 2'b10,
        START_R3   = 2'b11
    } start_code_e;

    typedef struct packed {
        start_code_e        start;
        logic [1:0]         opcode;
        logic [FRAME_W-5:0] rest;
    } frame_hdr_t;

    typedef struct packed {
        logic    busy;
        logic    rd;
        bitcnt_t bits;
        logic    smp;
    } engine_t;

    function automatic logic frame_is_read(frame_t f);
        frame_hdr_t h;
        h = frame_hdr_t'(f);
        case (h.start)
            START_BASE: return h.opcode == 2'b10;
            START_EXT:  return h.opcode[1];
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = DIV / 2;
    localparam int DW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [DW-1:0] cnt;

    assign rise_stb = run && (cnt == DW'(HALF - 1));
    assign fall_stb = run && (cnt == DW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (cnt == DW'(DIV - 1)) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            mdc <= (cnt + 1'b1) >= DW'(HALF);
        end
    end

    a_r3_low_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
    import mdio_mgmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  frame_t  wr_data,
    input  logic    rise_stb,
    input  logic    fall_stb,
    input  logic    drive_en,
    input  logic    pin_in,
    output frame_t  sreg,
    output engine_t st,
    output logic    done
);
    logic start;
    assign start = wr_en && !st.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            st   <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sreg    <= wr_data;
                st.busy <= 1'b1;
                st.rd   <= frame_is_read(wr_data);
                st.bits <= '0;
                st.smp  <= 1'b0;
            end else if (st.busy) begin
                if (rise_stb) begin
                    st.smp <= drive_en ? sreg[FRAME_W-1] : pin_in;
                end
                if (fall_stb) begin
                    sreg    <= {sreg[FRAME_W-2:0], st.smp};
                    st.bits <= st.bits + 1'b1;
                    if (st.bits == bitcnt_t'(FRAME_W - 1)) begin
                        st.busy <= 1'b0;
                        done    <= 1'b1;
                    end
                end
            end
        end
    end

    a_r11_hold_between_shifts: assert property (@(posedge clk) disable iff (rst)
        (st.busy && !fall_stb) |=> $stable(sreg));

    a_r5_bits_bounded: assert property (@(posedge clk) disable iff (rst)
        st.busy |-> (st.bits < bitcnt_t'(FRAME_W)));

    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!st.busy && $past(st.busy)));

endmodule

// File: rtl/mdio_pad_ctl.sv
module mdio_pad_ctl
    import mdio_mgmt_pkg::*;
(
    input  engine_t st,
    output logic    oe
);
    logic in_data_phase;
    assign in_data_phase = st.bits >= bitcnt_t'(HDR_W);
    assign oe = st.busy && !(st.rd && in_data_phase);
endmodule

// File: rtl/mdio_mgmt_shift.sv
module mdio_mgmt_shift
    import mdio_mgmt_pkg::*;
#(
    parameter int MDC_DIV = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mgmt_idle,
    output logic        mgmt_irq,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    frame_t  sreg;
    engine_t st;
    logic    rise_stb, fall_stb, start;

    assign start = host_wr && !st.busy;

    mdio_mdc_div #(.DIV(MDC_DIV)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (st.busy),
        .restart  (start),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_wr),
        .wr_data  (host_wdata),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .drive_en (mdio_oe),
        .pin_in   (mdio_in),
        .sreg     (sreg),
        .st       (st),
        .done     (mgmt_irq)
    );

    mdio_pad_ctl u_pad (
        .st (st),
        .oe (mdio_oe)
    );

    assign host_rdata = sreg;
    assign mgmt_idle  = !st.busy;
    assign mdio_out   = sreg[FRAME_W-1];

    a_r4_out_steady_while_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_out));

    a_r6_irq_on_idle_rise: assert property (@(posedge clk) disable iff (rst)
        mgmt_irq |-> (mgmt_idle && !$past(mgmt_idle)));

    a_r3_mdc_low_idle: assert property (@(posedge clk) disable iff (rst)
        (mgmt_idle && $past(mgmt_idle)) |-> !mdc);

endmodule

// File: tb/mdio_mgmt_shift_bench.sv
module mdio_mgmt_shift_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;
    localparam int FRAME_CLKS = 32 * DIV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mgmt_idle, mgmt_irq, mdc, mdio_out, mdio_oe, mdio_in;

    int n_checks = 0;
    int n_fails = 0;
    int rises = 0;
    logic [15:0] pat = '0;
    logic [31:0] obs_o = '0;
    logic [31:0] obs_oe = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdio_mgmt_shift #(.MDC_DIV(DIV)) u_mdio_mgmt_shift (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .mgmt_idle(mgmt_idle), .mgmt_irq(mgmt_irq),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    // PHY model: answers bit positions 16..31 with the pattern, MSB first
    assign mdio_in = (rises >= 16 && rises < 32) ? pat[4'(31 - rises)] : 1'b1;

    always @(posedge mdc) begin
        if (rises < 32) begin
            obs_o[31 - rises]  = mdio_out;
            obs_oe[31 - rises] = mdio_oe;
        end
        rises = rises + 1;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [31:0] w);
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_done(inout int n, inout int irqs);
        while (!mgmt_idle && n < 4 * FRAME_CLKS) begin
            @(posedge clk); #1;
            n++;
            if (mgmt_irq) irqs++;
        end
        @(posedge clk); #1;
        if (mgmt_irq) irqs++;
    endtask

    task automatic test_reset();
        check("R1 idle", 32'(mgmt_idle), 32'd1);
        check("R1 irq", 32'(mgmt_irq), 32'd0);
        check("R1 mdc", 32'(mdc), 32'd0);
        check("R1 oe", 32'(mdio_oe), 32'd0);
        check("R1 rdata", host_rdata, 32'd0);
    endtask

    task automatic run_frame(string req, logic [31:0] w, logic [15:0] p, bit is_rd);
        int n = 0;
        int irqs = 0;
        pat = p;
        rises = 0;
        obs_o = '0;
        obs_oe = '0;
        host_write(w);
        check("R2 idle drops", 32'(mgmt_idle), 32'd0);
        check("R2 first bit", 32'(mdio_out), 32'(w[31]));
        wait_done(n, irqs);
        check({"R5 frame length ", req}, 32'(n), 32'(FRAME_CLKS));
        check({"R6 irq pulses ", req}, 32'(irqs), 32'd1);
        check({"R4 header stream ", req}, 32'(obs_o[31:16]), 32'(w[31:16]));
        if (is_rd) begin
            check({req, " result"}, host_rdata, {w[31:16], p});
            check({req, " oe"}, obs_oe, 32'hFFFF_0000);
        end else begin
            check({req, " result"}, host_rdata, w);
            check({req, " oe"}, obs_oe, 32'hFFFF_FFFF);
            check({req, " stream"}, obs_o, w);
        end
        check({"R3 mdc idle ", req}, 32'(mdc), 32'd0);
    endtask

    task automatic test_mdc_shape();
        int n = 0;
        int irqs = 0;
        rises = 0;
        host_write(32'h5123_4567);
        for (int j = 0; j < 2 * DIV; j++) begin
            check("R3 mdc phase", 32'(mdc), 32'((j % DIV) >= DIV / 2));
            @(posedge clk); #1;
            n++;
        end
        wait_done(n, irqs);
        check("R5 mdc test length", 32'(n), 32'(FRAME_CLKS));
    endtask

    task automatic test_live_read();
        int n = 0;
        int irqs = 0;
        logic [31:0] w = 32'h5A3C_9E71;
        rises = 0;
        host_write(w);
        repeat (5 * DIV) begin
            @(posedge clk); n++;
        end
        #1;
        check("R7 live rotate 5", host_rdata, {w[26:0], w[31:27]});
        repeat (7 * DIV) begin
            @(posedge clk); n++;
        end
        #1;
        check("R7 live rotate 12", host_rdata, {w[19:0], w[31:20]});
        wait_done(n, irqs);
        check("R7 restored", host_rdata, w);
    endtask

    task automatic test_busy_write();
        int n = 0;
        int irqs = 0;
        logic [31:0] w1 = 32'h5F0F_1234;
        rises = 0;
        obs_o = '0;
        host_write(w1);
        repeat (10) begin
            @(posedge clk); n++;
        end
        host_write(32'h1BAD_CAFE);
        n++;
        #1;
        check("R11 still busy", 32'(mgmt_idle), 32'd0);
        wait_done(n, irqs);
        check("R11 completion time", 32'(n), 32'(FRAME_CLKS));
        check("R11 contents kept", host_rdata, w1);
        check("R11 stream kept", obs_o, w1);
        check("R11 irq once", 32'(irqs), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        test_reset();
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        test_reset();
        run_frame("R8 c22 write", 32'h5A3C_9E71, 16'h0000, 1'b0);
        run_frame("R9 c22 read", 32'h6B2E_55AA, 16'hC3A5, 1'b1);
        run_frame("R10 c45 read", 32'h3C8A_1234, 16'h0F1E, 1'b1);
        run_frame("R10 c45 read-inc", 32'h2C8A_FFFF, 16'h8001, 1'b1);
        run_frame("R10 c45 write", 32'h1C8A_BEEF, 16'hFFFF, 1'b0);
        run_frame("R10 c45 addr", 32'h0C8A_0042, 16'h5555, 1'b0);
        run_frame("R8 odd start", 32'hF00D_4321, 16'hAAAA, 1'b0);
        test_mdc_shape();
        test_live_read();
        test_busy_write();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule